// File: doc/BRIEF.md
# Gap-Free Symbol Packer for Partial Stream Beats

The block takes a stream of beats, each sixteen 8-bit symbols wide, in which a beat may carry fewer than sixteen symbols. An empty count says how many symbols at the top of the bus are unused. The valid symbols sit at the low end of the bus. The block writes them into a wide message register, starting right after the last symbol stored, so that beats of any length join up with no holes between them. A running write pointer, counted in symbols, turns into one write enable per symbol slot. Each slot selects the input symbol at its distance from the pointer.

When a beat fills the last slot, or would run past it, the block keeps only the symbols that fit and discards the rest. It raises a one-cycle done strobe and freezes the message, so downstream logic can read the whole register in parallel. While the message waits, the ready output is low. A restart input clears the whole register, returns the pointer to slot zero and opens the block for the next message. The message length is a parameter given in full beats. By default it is 100 beats, which is 1600 symbols or 12,800 bits.

Top module: `beat_compactor`

## Requirements
- R1: After a synchronous reset, `msg_data` is all zeros, `msg_done` is 0 and `in_ready` is 1. The write pointer is at slot 0.
- R2: An accepted beat (`in_valid` and `in_ready` both 1, `restart` 0) carries 16 minus `in_empty` valid symbols. These are the symbols in bits N*8-1..0, symbol k in bits k*8+7..k*8. Symbol k is stored in message slot pointer+k, which is `msg_data` bits (pointer+k)*8+7..(pointer+k)*8. Example: a one-symbol beat fills bits 7..0, and a two-symbol beat after it fills bits 23..8.
- R3: A cycle with `in_valid` low writes nothing, and the pointer does not move.
- R4: After each accepted beat, the pointer advances by its valid-symbol count. A beat with `in_empty` = 0 advances it by 16 slots (128 bits).
- R5: When a beat would reach or pass the end of the message, only the symbols that fit are stored and the rest are discarded.
- R6: The cycle after a beat that reaches or passes the end of the message, `msg_done` is 1 for exactly one cycle. This includes a beat that lands exactly on the end.
- R7: From the completing beat until a restart, `in_ready` is 0, beats are ignored and `msg_data` stays unchanged.
- R8: `restart` clears all of `msg_data`, sets the pointer to 0 and sets `in_ready` to 1 on the next cycle. It wins over a beat presented in the same cycle, which is dropped.
- R9: Slots not written since the last reset or restart read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on `in_data` |
| in_data | input | 128 | Sixteen 8-bit symbols, valid ones at the low end |
| in_empty | input | 4 | Number of unused symbols at the top of the beat (0..15) |
| in_ready | output | 1 | Block accepts beats (low while a finished message waits) |
| restart | input | 1 | Clear the message and begin a new one |
| msg_data | output | MSG_BEATS*128 | Assembled message, slot 0 in the low bits |
| msg_done | output | 1 | One-cycle strobe when the message is complete |

## Verification
The assertions check, on every cycle, the rules that concern the whole register:
- the done strobe lasts one cycle and coincides with ready being low;
- a held message stays frozen until a restart;
- idle cycles change nothing;
- a restart leaves an all-zero register with ready high;
- reset leads to the idle state.

Where each symbol lands, which depends on the pointer built up over earlier beats, is shown only by the bench scenarios. These compare the full register after every beat with a model. The same applies to when the done strobe fires and to how the overflow at the end of the message is cut off.

// File: rtl/beat_compactor_pkg.sv
package beat_compactor_pkg;

    localparam int SYM_W     = 8;
    localparam int BEAT_SYMS = 16;
    localparam int BEAT_W    = SYM_W * BEAT_SYMS;
    localparam int IDX_W     = $clog2(BEAT_SYMS);
    localparam int CNT_W     = $clog2(BEAT_SYMS + 1);

    typedef logic [SYM_W-1:0]            sym_t;
    typedef sym_t [BEAT_SYMS-1:0]        beat_syms_t;
    typedef logic [CNT_W-1:0]            sym_cnt_t;
    typedef logic [IDX_W-1:0]            sym_idx_t;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic       fire;
        sym_cnt_t   count;
        beat_syms_t syms;
    } beat_info_t;

    function automatic sym_cnt_t symbols_in_beat(input logic [IDX_W-1:0] empty_cnt);
        return sym_cnt_t'(BEAT_SYMS) - sym_cnt_t'(empty_cnt);
    endfunction

endpackage

// File: rtl/beat_compactor_decode.sv
module beat_compactor_decode
    import beat_compactor_pkg::*;
(
    input  logic                 in_valid,
    input  logic                 in_ready,
    input  logic                 restart,
    input  logic [BEAT_W-1:0]    in_data,
    input  logic [IDX_W-1:0]     in_empty,
    output beat_info_t           beat
);

    beat_syms_t syms_unpacked;

    generate
        for (genvar s = 0; s < BEAT_SYMS; s++) begin : g_unpack
            assign syms_unpacked[s] = in_data[s*SYM_W +: SYM_W];
        end
    endgenerate

    always_comb begin
        beat.fire  = in_valid && in_ready && !restart;
        beat.count = symbols_in_beat(in_empty);
        beat.syms  = syms_unpacked;
    end

endmodule

// File: rtl/beat_compactor_ctrl.sv
module beat_compactor_ctrl
    import beat_compactor_pkg::*;
#(
    parameter int MSG_SYMS = 1600,
    parameter int PTR_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             fire,
    input  sym_cnt_t         count,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] take,
    output logic             ready,
    output logic             done
);

    localparam logic [PTR_W-1:0] LAST_POS = PTR_W'(MSG_SYMS);

    fill_state_e       state_q, state_d;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    logic [PTR_W-1:0]  room;
    logic [PTR_W-1:0]  count_ext;
    logic              reaches_end;
    logic              done_q, done_d;

    always_comb begin
        count_ext   = PTR_W'(count);
        room        = LAST_POS - ptr_q;
        reaches_end = (count_ext >= room);
        take        = reaches_end ? room : count_ext;
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        done_d  = 1'b0;
        if (restart) begin
            state_d = ST_FILL;
            ptr_d   = '0;
        end else if (fire) begin
            if (reaches_end) begin
                state_d = ST_HOLD;
                ptr_d   = LAST_POS;
                done_d  = 1'b1;
            end else begin
                ptr_d   = ptr_q + count_ext;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            done_q  <= done_d;
        end
    end

    assign wr_ptr = ptr_q;
    assign ready  = (state_q == ST_FILL);
    assign done   = done_q;

endmodule

// File: rtl/beat_compactor_slots.sv
module beat_compactor_slots
    import beat_compactor_pkg::*;
#(
    parameter int MSG_SYMS = 1600,
    parameter int PTR_W    = 11
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      fire,
    input  beat_syms_t                syms,
    input  logic [PTR_W-1:0]          wr_ptr,
    input  logic [PTR_W-1:0]          take,
    output logic [MSG_SYMS*SYM_W-1:0] msg
);

    logic [PTR_W:0] win_lo;
    logic [PTR_W:0] win_hi;

    assign win_lo = {1'b0, wr_ptr};
    assign win_hi = {1'b0, wr_ptr} + {1'b0, take};

    generate
        for (genvar i = 0; i < MSG_SYMS; i++) begin : g_slot
            localparam logic [PTR_W:0] SLOT_POS = (PTR_W+1)'(i);

            sym_t     slot_q;
            logic     hit;
            sym_idx_t pick;

            assign hit  = fire && (SLOT_POS >= win_lo) && (SLOT_POS < win_hi);
            assign pick = IDX_W'(SLOT_POS - win_lo);

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    slot_q <= '0;
                end else if (hit) begin
                    slot_q <= syms[pick];
                end
            end

            assign msg[i*SYM_W +: SYM_W] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/beat_compactor.sv
module beat_compactor
    import beat_compactor_pkg::*;
#(
    parameter int MSG_BEATS = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [BEAT_W-1:0]             in_data,
    input  logic [IDX_W-1:0]              in_empty,
    output logic                          in_ready,
    input  logic                          restart,
    output logic [MSG_BEATS*BEAT_W-1:0]   msg_data,
    output logic                          msg_done
);

    localparam int MSG_SYMS = MSG_BEATS * BEAT_SYMS;
    localparam int PTR_W    = $clog2(MSG_SYMS + 1);
    localparam int MSG_W    = MSG_SYMS * SYM_W;

    beat_info_t        beat;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  take;

    beat_compactor_decode u_decode (
        .in_valid (in_valid),
        .in_ready (in_ready),
        .restart  (restart),
        .in_data  (in_data),
        .in_empty (in_empty),
        .beat     (beat)
    );

    beat_compactor_ctrl #(
        .MSG_SYMS (MSG_SYMS),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .fire    (beat.fire),
        .count   (beat.count),
        .wr_ptr  (wr_ptr),
        .take    (take),
        .ready   (in_ready),
        .done    (msg_done)
    );

    beat_compactor_slots #(
        .MSG_SYMS (MSG_SYMS),
        .PTR_W    (PTR_W)
    ) u_slots (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .fire    (beat.fire),
        .syms    (beat.syms),
        .wr_ptr  (wr_ptr),
        .take    (take),
        .msg     (msg_data)
    );

endmodule

// File: rtl/beat_compactor_chk.sv
module beat_compactor_chk #(
    parameter int MSG_W = 12800
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             restart,
    input logic             in_ready,
    input logic             msg_done,
    input logic [MSG_W-1:0] msg_data
);

    // R1: reset leaves the idle, empty state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (msg_data == '0 && !msg_done && in_ready));

    // R3: idle input cycles leave the message untouched
    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !restart) |=> $stable(msg_data));

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> !msg_done);

    // R6, R7: a done strobe always comes with the hold state
    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> !in_ready);

    // R7: a held message stays frozen until restart
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !restart) |=> ($stable(msg_data) && !in_ready));

    // R8: restart empties the register and reopens input
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (msg_data == '0 && in_ready && !msg_done));

endmodule

bind beat_compactor beat_compactor_chk #(.MSG_W(MSG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .restart  (restart),
    .in_ready (in_ready),
    .msg_done (msg_done),
    .msg_data (msg_data)
);

// File: tb/test_beat_compactor.sv
module test_beat_compactor;

    localparam int CLK_PERIOD = 10;
    localparam int BEATS      = 3;
    localparam int SYMS       = BEATS * 16;
    localparam int MW         = SYMS * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [127:0]  in_data;
    logic [3:0]    in_empty;
    logic          in_ready;
    logic          restart;
    logic [MW-1:0] msg_data;
    logic          msg_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [MW-1:0] exp_msg;
    int            exp_ptr;
    bit            exp_hold;
    bit            exp_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    beat_compactor #(.MSG_BEATS(BEATS)) i_beat_compactor (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_empty (in_empty),
        .in_ready (in_ready),
        .restart  (restart),
        .msg_data (msg_data),
        .msg_done (msg_done)
    );

    task automatic chk(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd_beat();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // model update following R2..R8
    task automatic model(input bit v, input logic [127:0] d, input logic [3:0] e, input bit rs);
        exp_done = 1'b0;
        if (rs) begin
            exp_msg  = '0;
            exp_ptr  = 0;
            exp_hold = 1'b0;
        end else if (v && !exp_hold) begin
            int cnt;
            cnt = 16 - int'(e);
            for (int k = 0; k < cnt; k++) begin
                if (exp_ptr + k < SYMS) exp_msg[(exp_ptr+k)*8 +: 8] = d[k*8 +: 8];
            end
            if (exp_ptr + cnt >= SYMS) begin
                exp_hold = 1'b1;
                exp_done = 1'b1;
                exp_ptr  = SYMS;
            end else begin
                exp_ptr = exp_ptr + cnt;
            end
        end
    endtask

    task automatic step(input string req, input bit v, input logic [127:0] d,
                        input logic [3:0] e, input bit rs);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        in_empty = e;
        restart  = rs;
        model(v, d, e, rs);
        @(posedge clk);
        #1;
        chk({req, " msg"},   msg_data, exp_msg);
        chk({req, " done"},  MW'(msg_done), MW'(exp_done));
        chk({req, " ready"}, MW'(in_ready), MW'(!exp_hold));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_empty = '0; restart = 1'b0;
        exp_msg = '0; exp_ptr = 0; exp_hold = 1'b0; exp_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 msg", msg_data, '0);
        chk("R1 done", MW'(msg_done), '0);
        chk("R1 ready", MW'(in_ready), MW'(1));
        @(negedge clk);
        rst = 1'b0;

        // R2: one-symbol beat to bits 7..0, then two-symbol beat to bits 23..8
        step("R2 one-symbol", 1'b1, 128'h00112233_44556677_8899aabb_ccdd00a5, 4'd15, 1'b0);
        chk("R2 bits7_0", MW'(msg_data[7:0]), MW'(8'ha5));
        step("R2 two-symbol", 1'b1, 128'hffffffff_ffffffff_ffffffff_ffff3c5a, 4'd14, 1'b0);
        chk("R2 bits23_8", MW'(msg_data[23:8]), MW'(16'h3c5a));
        // R9: slots above the pointer still zero
        chk("R9 unwritten zero", MW'(msg_data[MW-1:24]), '0);
        // R3: valid low with noisy data
        step("R3 idle", 1'b0, rnd_beat(), 4'd0, 1'b0);
        // R4: full beat advances 16 slots
        step("R4 full beat", 1'b1, rnd_beat(), 4'd0, 1'b0);
        step("R4 after full", 1'b1, rnd_beat(), 4'd12, 1'b0);
        // R5, R6: overflowing beat truncated (ptr 23, need 25 more)
        step("R4 fill", 1'b1, rnd_beat(), 4'd0, 1'b0);
        step("R5 R6 overflow", 1'b1, rnd_beat(), 4'd0, 1'b0);
        // R6: strobe drops, R7: beats ignored while holding
        step("R7 hold beat", 1'b1, rnd_beat(), 4'd0, 1'b0);
        step("R7 hold idle", 1'b0, rnd_beat(), 4'd3, 1'b0);
        // R8: restart wins over simultaneous beat
        step("R8 restart", 1'b1, rnd_beat(), 4'd0, 1'b1);
        chk("R8 zero", msg_data, '0);
        // R6: exact fit with three full beats
        for (int b = 0; b < BEATS; b++) step("R6 exact fit", 1'b1, rnd_beat(), 4'd0, 1'b0);
        step("R6 strobe drop", 1'b0, '0, 4'd0, 1'b0);
        step("R8 restart", 1'b0, '0, 4'd0, 1'b1);

        // random messages
        for (int m = 0; m < 40; m++) begin
            int guard;
            guard = 0;
            while (!exp_hold && guard < 200) begin
                bit v;
                v = ($urandom % 4) != 0;
                step("R2 R4 R5 random", v, rnd_beat(), 4'($urandom % 16), 1'b0);
                guard++;
            end
            step("R7 random hold", 1'b1, rnd_beat(), 4'($urandom % 16), 1'b0);
            step("R8 random restart", ($urandom % 2) == 1, rnd_beat(), 4'd0, 1'b1);
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule